// File: doc/BRIEF.md
# Cascadable Segment Line Loader

This block gathers one display line of pixel bits for a column driver of a liquid-crystal panel, in a form where several such drivers share one data bus and fill one after another. A line pulse resets the loader. It then waits, deselected, until an active-low enable pulse arrives from the previous chip in the chain. Once selected, it accepts data strobes and packs them into bytes. In wide mode one strobe carries a whole byte. In narrow mode two strobes each carry a nibble. Each byte goes into the next 8-bit group of a 160-bit staging buffer. The group order runs upward or downward, set by a direction input.

When the last group is written, the loader sends a one-cycle active-low enable pulse to the next chip. It raises a done flag and ignores further strobes until the next line pulse. All inputs are sampled on the rising edge of `clk`. The data strobe `xck_en` marks a cycle that carries data.

The control is a three-state machine:
- **IDLE** waits for enable. The transition *select* (enable sampled low) leads to LOAD.
- **LOAD** accepts data. The transition *fill_end* (the strobe that completes the last group) leads to DONE.
- **DONE** holds the finished line.
- The transition *line_reset* (line pulse) leads from any state to IDLE and takes priority over every other transition.

Top module: `seg_line_loader`

## Requirements
- R1: After reset, enable_out_n is 1, line_done is 0 and line_buf is all zeros.
- R2: In IDLE (after reset or a line pulse), strobes do not change line_buf. A strobe in the same cycle that enable_in_n is sampled low is also ignored. Data is accepted from the following cycle on.
- R3: With wide_mode=1, each accepted strobe writes din[7:0] into the next group. Group g occupies line_buf[8g+7:8g].
- R4: With wide_mode=0, two accepted strobes form one group. The first strobe's din[3:0] becomes bits 7:4 and the second strobe's din[3:0] becomes bits 3:0. din[7:4] is ignored.
- R5: With dir_rev=0, groups fill in the order 0,1,...,19. With dir_rev=1, they fill in the order 19,18,...,0.
- R6: In the cycle after the strobe that completes the 20th group, enable_out_n is 0 for exactly one cycle. From that cycle on, line_done is 1 until the next line pulse.
- R7: While line_done is 1, strobes do not change line_buf.
- R8: A cycle with lp=1 returns the loader to IDLE and clears line_done. It discards a half-assembled nibble and restarts the group order. It keeps line_buf contents. A strobe or enable in that cycle is ignored.
- R9: enable_in_n pulses while loading or done have no effect on loading order, line_buf or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp | input | 1 | Line pulse; restarts the loader |
| xck_en | input | 1 | Data strobe; din is valid this cycle |
| din | input | 8 | Parallel data; only bits 3:0 used in narrow mode |
| wide_mode | input | 1 | 1 = one byte per strobe, 0 = one nibble per strobe |
| dir_rev | input | 1 | 0 = groups fill upward, 1 = groups fill downward |
| enable_in_n | input | 1 | Active-low cascade enable from the previous chip |
| enable_out_n | output | 1 | Active-low one-cycle cascade enable to the next chip |
| line_done | output | 1 | High from line completion until the next line pulse |
| line_buf | output | 160 | Staged line data, group g at bits 8g+7:8g |

## Verification
The line pulse and the final completing strobe can land in the same cycle. The same holds for the line pulse and the enable that selects the chip. The bench drives both collisions on purpose: a wide line is stopped one byte short and the 20th strobe is issued together with `lp`. The behavioural model gives the pulse priority, so no cascade pulse appears, `line_done` stays low and that byte is not stored. A following enable must then start a fresh line at group 0.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } ld_state_t;
endpackage

// File: rtl/seg_byte_pack.sv
module seg_byte_pack #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic              wide,
    input  logic [WORD_W-1:0] din,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int NIB_W = WORD_W / 2;

    logic             half_q;
    logic [NIB_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            hold_q <= '0;
        end else if (clear || wide) begin
            half_q <= 1'b0;
        end else if (accept) begin
            half_q <= !half_q;
            if (!half_q) hold_q <= din[NIB_W-1:0];
        end
    end

    always_comb begin
        word_valid = accept && (wide || half_q);
        word       = wide ? din : {hold_q, din[NIB_W-1:0]};
    end
endmodule

// File: rtl/seg_group_seq.sv
module seg_group_seq #(
    parameter int GROUPS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic              dir_rev,
    output logic [GROUPS-1:0] grp_sel,
    output logic              last
);
    localparam int CW = $clog2(GROUPS);
    localparam logic [CW-1:0] LAST_IDX = CW'(GROUPS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (advance)     cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_sel
        localparam logic [CW-1:0] FWD = CW'(g);
        localparam logic [CW-1:0] REV = CW'(GROUPS - 1 - g);
        assign grp_sel[g] = (dir_rev ? REV : FWD) == cnt_q;
    end

    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/seg_stage_buf.sv
module seg_stage_buf #(
    parameter int GROUPS = 20,
    parameter int WORD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [GROUPS-1:0]        grp_sel,
    input  logic [WORD_W-1:0]        word,
    output logic [GROUPS*WORD_W-1:0] line_buf
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  line_buf[g*WORD_W +: WORD_W] <= '0;
            else if (we && grp_sel[g])   line_buf[g*WORD_W +: WORD_W] <= word;
        end
    end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
    import seg_loader_pkg::*;
#(
    parameter int GROUPS = 20,
    parameter int WORD_W = 8,
    localparam int LINE_W = GROUPS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp,
    input  logic              xck_en,
    input  logic [WORD_W-1:0] din,
    input  logic              wide_mode,
    input  logic              dir_rev,
    input  logic              enable_in_n,
    output logic              enable_out_n,
    output logic              line_done,
    output logic [LINE_W-1:0] line_buf
);
    ld_state_t         st_q, st_d;
    logic              accept, word_valid, last, fill_end;
    logic [WORD_W-1:0] word;
    logic [GROUPS-1:0] grp_sel;

    assign accept   = xck_en && (st_q == ST_LOAD) && !lp;
    assign fill_end = word_valid && last;

    seg_byte_pack #(.WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(lp), .accept(accept),
        .wide(wide_mode), .din(din), .word_valid(word_valid), .word(word)
    );

    seg_group_seq #(.GROUPS(GROUPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(lp), .advance(word_valid),
        .dir_rev(dir_rev), .grp_sel(grp_sel), .last(last)
    );

    seg_stage_buf #(.GROUPS(GROUPS), .WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(word_valid), .grp_sel(grp_sel),
        .word(word), .line_buf(line_buf)
    );

    always_comb begin
        st_d = st_q;
        if (lp) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (!enable_in_n) st_d = ST_LOAD;
                ST_LOAD: if (fill_end)     st_d = ST_DONE;
                ST_DONE: st_d = ST_DONE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_out_n <= 1'b1;
            line_done    <= 1'b0;
        end else begin
            enable_out_n <= !fill_end;
            if (lp)            line_done <= 1'b0;
            else if (fill_end) line_done <= 1'b1;
        end
    end
endmodule

// File: rtl/seg_line_loader_chk.sv
module seg_line_loader_chk
    import seg_loader_pkg::*;
#(
    parameter int LINE_W = 160
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lp,
    input logic              enable_out_n,
    input logic              line_done,
    input logic [LINE_W-1:0] line_buf,
    input ld_state_t         st_q
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_out_n |=> enable_out_n);

    a_r6_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_out_n |-> line_done);

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && !lp) |=> line_done);

    a_r8_lp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lp |=> (!line_done && enable_out_n));

    a_r7_buf_frozen_done: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> $stable(line_buf));

    a_r2_buf_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> $stable(line_buf));
endmodule

bind seg_line_loader seg_line_loader_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lp(lp), .enable_out_n(enable_out_n),
    .line_done(line_done), .line_buf(line_buf), .st_q(st_q)
);

// File: tb/seg_line_loader_bench.sv
module seg_line_loader_bench;
    localparam int NG = 20;
    localparam int LW = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lp = 1'b0, xck_en = 1'b0, wide_mode = 1'b1, dir_rev = 1'b0;
    logic          enable_in_n = 1'b1;
    logic [7:0]    din = '0;
    logic          enable_out_n, line_done;
    logic [LW-1:0] line_buf;

    int n_checks = 0, n_fail = 0, eo_count = 0;
    string phase = "R1";

    // behavioural model
    int          m_state = 0; // 0 idle, 1 load, 2 done
    int          m_cnt = 0;
    bit          m_half = 0;
    logic [3:0]  m_hold = '0;
    logic [LW-1:0] m_buf = '0;
    logic        m_eo = 1'b1, m_done = 1'b0;

    always #5 clk = !clk;

    seg_line_loader u_seg_line_loader (
        .clk(clk), .rst_n(rst_n), .lp(lp), .xck_en(xck_en), .din(din),
        .wide_mode(wide_mode), .dir_rev(dir_rev), .enable_in_n(enable_in_n),
        .enable_out_n(enable_out_n), .line_done(line_done), .line_buf(line_buf)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_half = 0; m_hold = '0;
            m_buf = '0; m_eo = 1'b1; m_done = 1'b0;
        end else begin
            logic [7:0] b;
            bit         have;
            int         idx;
            m_eo = 1'b1;
            if (lp) begin
                m_state = 0; m_cnt = 0; m_half = 0; m_done = 1'b0;
            end else if (m_state == 0) begin
                if (!enable_in_n) m_state = 1;
            end else if (m_state == 1 && xck_en) begin
                have = 0;
                if (wide_mode) begin b = din; have = 1; m_half = 0; end
                else if (m_half) begin b = {m_hold, din[3:0]}; have = 1; m_half = 0; end
                else begin m_hold = din[3:0]; m_half = 1; end
                if (have) begin
                    idx = dir_rev ? (NG - 1 - m_cnt) : m_cnt;
                    m_buf[idx*8 +: 8] = b;
                    if (m_cnt == NG - 1) begin
                        m_state = 2; m_eo = 1'b0; m_done = 1'b1; m_cnt = 0;
                    end else m_cnt++;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " enable_out_n"}, LW'(enable_out_n), LW'(m_eo));
            check({phase, " line_done"}, LW'(line_done), LW'(m_done));
            check({phase, " line_buf"}, line_buf, m_buf);
            if (!enable_out_n) eo_count++;
        end
    end

    task automatic step(input logic l, input logic x, input logic e_n, input logic [7:0] d);
        @(posedge clk); #1;
        lp = l; xck_en = x; enable_in_n = e_n; din = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 8'h00);
    endtask

    function automatic logic [7:0] pat_a(input int k); return 8'(k * 37 + 5); endfunction
    function automatic logic [7:0] pat_b(input int k); return 8'(k * 29 + 3); endfunction

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [LW-1:0] exp;
        int            eo0;
        #23;
        check("R1 enable_out_n", LW'(enable_out_n), LW'(1'b1));
        check("R1 line_done", LW'(line_done), LW'(1'b0));
        check("R1 line_buf", line_buf, '0);
        rst_n = 1'b1;
        idle(2);

        // R2, R3, R5 upward wide line
        phase = "R2";
        wide_mode = 1'b1; dir_rev = 1'b0;
        step(1, 0, 1, 0);
        step(0, 1, 1, 8'hEE); step(0, 1, 1, 8'hDD);
        step(0, 1, 0, 8'hCC);
        idle(1);
        check("R2 idle strobes ignored", line_buf, '0);
        phase = "R3";
        eo0 = eo_count;
        for (int k = 0; k < NG; k++) begin
            step(0, 1, 1, pat_a(k));
            if (k % 7 == 3) idle(1);
        end
        idle(2);
        exp = '0;
        for (int k = 0; k < NG; k++) exp[k*8 +: 8] = pat_a(k);
        check("R3 R5 upward wide line", line_buf, exp);
        check("R6 one cascade pulse", LW'(eo_count - eo0), LW'(1));
        check("R6 done flag", LW'(line_done), LW'(1'b1));
        phase = "R7";
        step(0, 1, 1, 8'h55); step(0, 1, 0, 8'h66);
        idle(2);
        check("R7 strobes ignored when done", line_buf, exp);
        check("R9 enable ignored when done", LW'(eo_count - eo0), LW'(1));

        // R4, R5 downward narrow line with stray enable
        phase = "R4";
        wide_mode = 1'b0; dir_rev = 1'b1;
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);
        eo0 = eo_count;
        for (int k = 0; k < NG; k++) begin
            logic [7:0] b;
            b = pat_b(k);
            step(0, 1, (k == 5) ? 1'b0 : 1'b1, {4'hA, b[7:4]});
            step(0, 1, 1, {4'h5, b[3:0]});
        end
        idle(2);
        for (int k = 0; k < NG; k++) exp[(NG-1-k)*8 +: 8] = pat_b(k);
        check("R4 R5 R9 downward narrow line", line_buf, exp);
        check("R6 narrow cascade pulse", LW'(eo_count - eo0), LW'(1));

        // R8 half nibble discarded by line pulse
        phase = "R8";
        dir_rev = 1'b0;
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);
        step(0, 1, 1, 8'h0F);
        step(1, 0, 1, 0);
        idle(1);
        check("R8 line pulse clears done", LW'(line_done), LW'(1'b0));
        step(0, 0, 0, 0);
        step(0, 1, 1, 8'h03); step(0, 1, 1, 8'h0C);
        idle(2);
        exp[7:0] = 8'h3C;
        check("R8 nibble discarded and order restarted", line_buf, exp);

        // R8 collision of line pulse with completing strobe
        wide_mode = 1'b1;
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);
        eo0 = eo_count;
        for (int k = 0; k < NG - 1; k++) step(0, 1, 1, 8'(k + 8'h40));
        step(1, 1, 0, 8'h99);
        idle(2);
        check("R8 collision no cascade pulse", LW'(eo_count - eo0), LW'(0));
        check("R8 collision not done", LW'(line_done), LW'(1'b0));
        step(0, 0, 0, 0);
        step(0, 1, 1, 8'h77);
        idle(2);
        check("R8 restart at group 0", LW'(line_buf[7:0]), LW'(8'h77));
        check("R8 byte kept", LW'(line_buf[15:8]), LW'(8'h41));

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule